// File: doc/BRIEF.md
# Oversampled Serial Receiver with Error Flags

This block turns a serial line into bytes. In the three asynchronous modes it watches for a start bit using a one-cycle enable tick that runs at sixteen times the bit rate. It checks that the start bit is real and then samples every following bit at its centre. In the synchronous mode the same tick acts as the bit clock, and each tick samples one bit. When a frame is complete, the received byte moves into a holding register and the ready flag is set. The flags for overrun, parity error, framing error and the received address bit are updated in that same clock cycle.

The CPU side follows a valid/ready rule. `rx_valid` is the valid signal and a one-cycle `data_rd` pulse is the ready signal. The host applies back-pressure simply by not reading. If a frame completes while `rx_valid` is still set, that frame is lost and counted as an overrun. The held byte is never overwritten. The error flags need a two-step read: first pulse `stat_rd`, then pulse `data_rd`. The tick generator lives outside this block. `cfg_mode` may change only while reset is asserted.

Top module: `serial_rx_core`

## Requirements
- R1: In the asynchronous modes, a low line seen while idle starts a candidate start bit. The frame is accepted only if the line is still low on the 8th tick after that first low tick. Otherwise the receiver returns to idle and nothing is stored.
- R2: The first bit after the start bit is bit 0 of the byte (LSB first). Each bit is sampled 16 ticks after the previous sample. The frame layout depends on `cfg_mode`:
  - 0: start, 8 data bits, stop.
  - 1: start, 8 data bits, parity, stop.
  - 2: start, 8 data bits, address bit, stop.
  - 3: synchronous.

  On a transfer, the byte appears on `rx_data` and `rx_valid` goes to 1.
- R3: In mode 1, `cfg_odd`=0 selects even parity and `cfg_odd`=1 selects odd parity. The parity check counts the ones in the 8 data bits plus the parity bit. A count that does not match the selected parity sets `rx_perr` on transfer. In every other mode `rx_perr` stays 0.
- R4: In modes 0 to 2, a stop bit sampled low sets `rx_ferr` in the same cycle as `rx_valid`. In mode 3, `rx_ferr` stays 0.
- R5: While `rx_ferr` is 1, completed frames are dropped. `rx_data` and `rx_valid` do not change and no overrun is flagged.
- R6: When a frame completes while `rx_valid` is 1, the following happens:
  - `rx_ovr` is set.
  - The new byte is dropped, so `rx_data` keeps its value.
  - `rx_perr` and `rx_ferr` are not updated from that frame.

  This rule does not apply when a `data_rd` pulse arrives in the same cycle as the frame completion.
- R7: A `data_rd` pulse always clears `rx_valid`. It also clears `rx_ovr`, `rx_perr` and `rx_ferr`, but only if a `stat_rd` pulse came after the previous `data_rd`. Otherwise those three flags are left unchanged.
- R8: In mode 2, the address bit is copied to `rx_addr` on each transfer (1 = address, 0 = data). Reads do not change `rx_addr`, and only reset clears it.
- R9: In mode 3, every tick samples one bit, LSB first. After 8 ticks a byte is complete and is transferred.
- R10: After reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | Enable pulse at 16x the bit rate (the bit strobe in mode 3) |
| rxd | input | 1 | Serial line, idles high |
| cfg_mode | input | 2 | Frame mode 0..3, see R2 |
| cfg_odd | input | 1 | Parity select: 1 = odd, 0 = even |
| stat_rd | input | 1 | Status read strobe |
| data_rd | input | 1 | Data read strobe (ready) |
| rx_data | output | 8 | Received byte |
| rx_valid | output | 1 | Byte available (valid) |
| rx_ovr | output | 1 | Overrun flag |
| rx_perr | output | 1 | Parity error flag |
| rx_ferr | output | 1 | Framing error flag |
| rx_addr | output | 1 | Last received address bit |

## Verification
Each mode is tried with at least two different bytes. In the parity mode, the tests set the parity bit and `cfg_odd` in combinations that tell the even and odd checks apart. A short low glitch on an idle line tests the start-bit check: it must not be taken as a start bit. A frame with a low stop bit, followed by a good frame, shows the blocking rule. That good frame must change nothing until the status-then-data sequence has run. A frame with both a parity error and a framing error, sent while the previous byte is still unread, shows that overrun takes priority. The address-bit tests and the synchronous-mode tests use bytes whose bit patterns catch a reversed bit order.

// File: rtl/rxs_pkg.sv
package rxs_pkg;
  typedef enum logic [1:0] {
    MODE_PLAIN  = 2'd0,
    MODE_PARITY = 2'd1,
    MODE_ADDR   = 2'd2,
    MODE_SYNC   = 2'd3
  } rx_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_SHIFT = 2'd2
  } rx_state_e;
endpackage

// File: rtl/rxs_sync.sv
module rxs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[g] <= 1'b1;
        else if (g == 0) chain[g] <= din;
        else chain[g] <= chain[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/rxs_framer.sv
module rxs_framer
  import rxs_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OSR    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              line,
  input  rx_mode_e          mode,
  output logic              done,
  output logic [DATA_W-1:0] word,
  output logic              bit9,
  output logic              stop_ok
);
  localparam int FRM_W = DATA_W + 2;
  localparam int IDX_W = $clog2(FRM_W);
  localparam int CNT_W = $clog2(OSR);
  localparam int HALF  = OSR / 2;

  rx_state_e        state;
  logic [CNT_W-1:0] cnt;
  logic [IDX_W-1:0] idx;
  logic [IDX_W-1:0] last_idx;
  logic [FRM_W-1:0] frm;

  always_comb begin
    case (mode)
      MODE_PLAIN: last_idx = IDX_W'(DATA_W);
      MODE_SYNC:  last_idx = IDX_W'(DATA_W - 1);
      default:    last_idx = IDX_W'(DATA_W + 1);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
      idx   <= '0;
      frm   <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (tick) begin
        if (mode == MODE_SYNC) begin
          frm[idx] <= line;
          if (idx == last_idx) begin
            idx  <= '0;
            done <= 1'b1;
          end else begin
            idx <= idx + 1'b1;
          end
        end else begin
          case (state)
            ST_IDLE: begin
              if (!line) begin
                state <= ST_START;
                cnt   <= '0;
              end
            end
            ST_START: begin
              if (cnt == CNT_W'(HALF - 1)) begin
                cnt   <= '0;
                idx   <= '0;
                state <= line ? ST_IDLE : ST_SHIFT;
              end else begin
                cnt <= cnt + 1'b1;
              end
            end
            ST_SHIFT: begin
              if (cnt == CNT_W'(OSR - 1)) begin
                cnt      <= '0;
                frm[idx] <= line;
                if (idx == last_idx) begin
                  done  <= 1'b1;
                  state <= ST_IDLE;
                end else begin
                  idx <= idx + 1'b1;
                end
              end else begin
                cnt <= cnt + 1'b1;
              end
            end
            default: state <= ST_IDLE;
          endcase
        end
      end
    end
  end

  assign word    = frm[DATA_W-1:0];
  assign bit9    = frm[DATA_W];
  assign stop_ok = (mode == MODE_PLAIN) ? frm[DATA_W] : frm[DATA_W+1];
endmodule

// File: rtl/rxs_flags.sv
module rxs_flags
  import rxs_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  rx_mode_e          mode,
  input  logic              odd,
  input  logic              done,
  input  logic [DATA_W-1:0] word,
  input  logic              bit9,
  input  logic              stop_ok,
  input  logic              stat_rd,
  input  logic              data_rd,
  output logic [DATA_W-1:0] data_q,
  output logic              rdy,
  output logic              ovr,
  output logic              pe,
  output logic              fe,
  output logic              addr
);
  logic armed;
  logic par_bad;

  assign par_bad = (^{bit9, word}) ^ odd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      rdy    <= 1'b0;
      ovr    <= 1'b0;
      pe     <= 1'b0;
      fe     <= 1'b0;
      addr   <= 1'b0;
      armed  <= 1'b0;
    end else begin
      if (stat_rd) armed <= 1'b1;
      if (data_rd) begin
        rdy   <= 1'b0;
        armed <= stat_rd;
        if (armed) begin
          ovr <= 1'b0;
          pe  <= 1'b0;
          fe  <= 1'b0;
        end
      end
      if (done && !fe) begin
        if (rdy && !data_rd) begin
          ovr <= 1'b1;
        end else begin
          data_q <= word;
          rdy    <= 1'b1;
          if (mode != MODE_SYNC && !stop_ok) fe <= 1'b1;
          if (mode == MODE_PARITY && par_bad) pe <= 1'b1;
          if (mode == MODE_ADDR) addr <= bit9;
        end
      end
    end
  end
endmodule

// File: rtl/serial_rx_core.sv
module serial_rx_core
  import rxs_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int OSR         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick16,
  input  logic              rxd,
  input  logic [1:0]        cfg_mode,
  input  logic              cfg_odd,
  input  logic              stat_rd,
  input  logic              data_rd,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              rx_ovr,
  output logic              rx_perr,
  output logic              rx_ferr,
  output logic              rx_addr
);
  rx_mode_e          mode;
  logic              line_s;
  logic              frm_done;
  logic [DATA_W-1:0] frm_word;
  logic              frm_bit9;
  logic              frm_stop;

  assign mode = rx_mode_e'(cfg_mode);

  rxs_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst_n(rst_n),
    .din (rxd),
    .dout(line_s)
  );

  rxs_framer #(.DATA_W(DATA_W), .OSR(OSR)) u_framer (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick16),
    .line   (line_s),
    .mode   (mode),
    .done   (frm_done),
    .word   (frm_word),
    .bit9   (frm_bit9),
    .stop_ok(frm_stop)
  );

  rxs_flags #(.DATA_W(DATA_W)) u_flags (
    .clk    (clk),
    .rst_n  (rst_n),
    .mode   (mode),
    .odd    (cfg_odd),
    .done   (frm_done),
    .word   (frm_word),
    .bit9   (frm_bit9),
    .stop_ok(frm_stop),
    .stat_rd(stat_rd),
    .data_rd(data_rd),
    .data_q (rx_data),
    .rdy    (rx_valid),
    .ovr    (rx_ovr),
    .pe     (rx_perr),
    .fe     (rx_ferr),
    .addr   (rx_addr)
  );
endmodule

// File: rtl/rxs_checker.sv
module rxs_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        cfg_mode,
  input logic              data_rd,
  input logic              frame_done,
  input logic [DATA_W-1:0] rx_data,
  input logic              rx_valid,
  input logic              rx_ovr,
  input logic              rx_perr,
  input logic              rx_ferr,
  input logic              rx_addr
);
  assert_ferr_with_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_ferr) |-> rx_valid);

  assert_sync_no_ferr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode == 2'd3) |-> !rx_ferr);

  assert_perr_only_parity_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode != 2'd1) |-> !rx_perr);

  assert_ferr_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ferr |=> $stable(rx_data));

  assert_ovr_priority_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_ovr) |-> ($stable(rx_perr) && $stable(rx_ferr) && $stable(rx_data)));

  assert_ferr_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_ferr) |-> $past(data_rd));

  assert_valid_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_valid) |-> $past(data_rd));

  assert_addr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_done |=> $stable(rx_addr));
endmodule

bind serial_rx_core rxs_checker #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_mode  (cfg_mode),
  .data_rd   (data_rd),
  .frame_done(frm_done),
  .rx_data   (rx_data),
  .rx_valid  (rx_valid),
  .rx_ovr    (rx_ovr),
  .rx_perr   (rx_perr),
  .rx_ferr   (rx_ferr),
  .rx_addr   (rx_addr)
);

// File: tb/serial_rx_core_tb.sv
module serial_rx_core_tb;
  localparam int BITCLK = 64;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       auto_tick = 1'b0;
  logic       man_tick = 1'b0;
  logic       tick_en = 1'b1;
  logic [1:0] tdiv = '0;
  logic       rxd = 1'b1;
  logic [1:0] cfg_mode = 2'd0;
  logic       cfg_odd = 1'b0;
  logic       stat_rd = 1'b0;
  logic       data_rd = 1'b0;
  logic [7:0] rx_data;
  logic       rx_valid, rx_ovr, rx_perr, rx_ferr, rx_addr;
  int         total = 0;
  int         bad = 0;
  bit         finished = 1'b0;

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    tdiv      <= tdiv + 2'd1;
    auto_tick <= tick_en && (tdiv == 2'd3);
  end

  serial_rx_core u_dut (
    .clk(clk), .rst_n(rst_n), .tick16(auto_tick | man_tick), .rxd(rxd),
    .cfg_mode(cfg_mode), .cfg_odd(cfg_odd), .stat_rd(stat_rd), .data_rd(data_rd),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_ovr(rx_ovr), .rx_perr(rx_perr),
    .rx_ferr(rx_ferr), .rx_addr(rx_addr)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [1:0] m, input logic odd, input logic te);
    @(negedge clk);
    rst_n = 1'b0; cfg_mode = m; cfg_odd = odd; tick_en = te; rxd = 1'b1;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic hold(input logic v, input int n);
    rxd = v;
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input logic has9, input logic b9, input logic stop);
    @(negedge clk);
    hold(1'b0, BITCLK);
    for (int i = 0; i < 8; i++) hold(d[i], BITCLK);
    if (has9) hold(b9, BITCLK);
    if (stop) hold(1'b1, BITCLK);
    else hold(1'b0, 48);
    hold(1'b1, 2 * BITCLK);
  endtask

  task automatic rd_stat();
    @(negedge clk) stat_rd = 1'b1;
    @(negedge clk) stat_rd = 1'b0;
  endtask

  task automatic rd_data();
    @(negedge clk) data_rd = 1'b1;
    @(negedge clk) data_rd = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset(2'd0, 1'b0, 1'b1);
    chk("R10 data", rx_data, 8'h00);
    chk("R10 flags", {3'b0, rx_valid, rx_ovr, rx_perr, rx_ferr, rx_addr}, 8'h00);
  endtask

  task automatic t_basic();
    do_reset(2'd0, 1'b0, 1'b1);
    send(8'hA5, 1'b0, 1'b0, 1'b1);
    chk("R2 data A5", rx_data, 8'hA5);
    chk("R2 valid", {7'b0, rx_valid}, 8'h01);
    chk("R4 no ferr", {7'b0, rx_ferr}, 8'h00);
    rd_data();
    chk("R7 valid cleared", {7'b0, rx_valid}, 8'h00);
    send(8'h3C, 1'b0, 1'b0, 1'b1);
    chk("R2 data 3C", rx_data, 8'h3C);
  endtask

  task automatic t_glitch();
    do_reset(2'd0, 1'b0, 1'b1);
    @(negedge clk);
    hold(1'b0, 16);
    hold(1'b1, 15 * BITCLK);
    chk("R1 glitch rejected", {7'b0, rx_valid}, 8'h00);
    send(8'h81, 1'b0, 1'b0, 1'b1);
    chk("R1 next frame ok", rx_data, 8'h81);
  endtask

  task automatic t_parity();
    do_reset(2'd1, 1'b0, 1'b1);
    send(8'h03, 1'b1, 1'b0, 1'b1);
    chk("R3 even ok", {rx_valid, rx_perr}, {1'b1, 1'b0});
    rd_stat(); rd_data();
    send(8'h07, 1'b1, 1'b0, 1'b1);
    chk("R3 even bad", {7'b0, rx_perr}, 8'h01);
    rd_data();
    chk("R7 perr kept without status", {7'b0, rx_perr}, 8'h01);
    rd_stat(); rd_data();
    chk("R7 perr cleared", {7'b0, rx_perr}, 8'h00);
    cfg_odd = 1'b1;
    send(8'h07, 1'b1, 1'b0, 1'b1);
    chk("R3 odd ok", {rx_valid, rx_perr}, {1'b1, 1'b0});
    rd_stat(); rd_data();
    send(8'h03, 1'b1, 1'b0, 1'b1);
    chk("R3 odd bad", {7'b0, rx_perr}, 8'h01);
  endtask

  task automatic t_ferr();
    do_reset(2'd0, 1'b0, 1'b1);
    send(8'h55, 1'b0, 1'b0, 1'b0);
    chk("R4 ferr and valid", {rx_valid, rx_ferr}, {1'b1, 1'b1});
    chk("R4 data", rx_data, 8'h55);
    rd_data();
    chk("R7 ferr kept", {rx_valid, rx_ferr}, {1'b0, 1'b1});
    send(8'h66, 1'b0, 1'b0, 1'b1);
    chk("R5 blocked data", rx_data, 8'h55);
    chk("R5 blocked flags", {rx_valid, rx_ovr}, {1'b0, 1'b0});
    rd_stat(); rd_data();
    chk("R7 ferr cleared", {7'b0, rx_ferr}, 8'h00);
    send(8'h66, 1'b0, 1'b0, 1'b1);
    chk("R5 resumes", rx_data, 8'h66);
  endtask

  task automatic t_overrun();
    do_reset(2'd1, 1'b0, 1'b1);
    send(8'h11, 1'b1, 1'b0, 1'b1);
    send(8'h22, 1'b1, 1'b1, 1'b0);
    chk("R6 ovr set", {rx_valid, rx_ovr}, {1'b1, 1'b1});
    chk("R6 errors suppressed", {rx_perr, rx_ferr}, {1'b0, 1'b0});
    chk("R6 data kept", rx_data, 8'h11);
    rd_stat(); rd_data();
    chk("R7 ovr cleared", {rx_valid, rx_ovr}, {1'b0, 1'b0});
  endtask

  task automatic t_addr();
    do_reset(2'd2, 1'b0, 1'b1);
    send(8'h42, 1'b1, 1'b1, 1'b1);
    chk("R8 addr set", {7'b0, rx_addr}, 8'h01);
    chk("R8 data", rx_data, 8'h42);
    rd_stat(); rd_data();
    chk("R8 addr kept after reads", {7'b0, rx_addr}, 8'h01);
    send(8'h43, 1'b1, 1'b0, 1'b1);
    chk("R8 addr data byte", {rx_addr, rx_data}, {1'b0, 8'h43});
  endtask

  task automatic t_sync();
    do_reset(2'd3, 1'b0, 1'b0);
    for (int k = 0; k < 2; k++) begin
      logic [7:0] d;
      d = (k == 0) ? 8'h9B : 8'h2E;
      for (int i = 0; i < 8; i++) begin
        @(negedge clk) rxd = d[i];
        repeat (3) @(negedge clk);
        man_tick = 1'b1;
        @(negedge clk) man_tick = 1'b0;
      end
      repeat (3) @(negedge clk);
      chk("R9 sync byte", rx_data, d);
      chk("R9 sync flags", {rx_valid, rx_perr, rx_ferr}, 3'b100);
      rd_data();
    end
  endtask

  initial begin
    t_reset();
    t_basic();
    t_glitch();
    t_parity();
    t_ferr();
    t_overrun();
    t_addr();
    t_sync();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule